// File: doc/BRIEF.md
# RS-485 Star Repeater Direction Controller

This block is the logic core of a star repeater that links one host-side RS-485 segment to ten device-side segments. Each side is seen at logic level as a receive line, a transmit line and a driver enable for its half-duplex transceiver. While nothing is happening, every transceiver listens and every transmit line rests at 1. The first side to pull its receive line low takes the hub. From then on the block copies that side's bit stream to the opposite side. Host traffic goes to all device ports at once. Traffic from a device port goes back to the host only.

Each output driver follows a zero-delay enable rule. The driver is on whenever the bit it sends is 0. After each rise to 1, it stays on and drives the high level for a short, programmable number of clock cycles. It then lets go, and the line's bias resistors keep the idle high. Ownership of the hub ends only after the owning input has been high without a break for a programmable quiet window of about two characters. This stops the direction from flipping between bits and stops data from echoing back into its source.

Top module: `star_hub_dir_ctrl`

## Requirements
- R1: During and right after a synchronous reset, every transmit line is 1 and every driver enable is 0.
- R2: When the hub is idle and the host receive line goes low, all device ports repeat the host level. A change at an input appears at the outputs on the third rising clock edge after it. The host-side driver stays off.
- R3: When a device port owns the hub, its level is repeated on the host transmit line only. No device port transmits 0 and no device-port enable is raised, including on the source port.
- R4: Every driver whose transmit line is 0 has its enable at 1.
- R5: When a driven transmit line rises from 0 to 1, its enable stays at 1 for exactly HOLD_CYCLES clock cycles with the line at 1. The enable then drops to 0.
- R6: Ownership ends once the owning input has been seen at 1 for RELEASE_CYCLES consecutive cycles. A low on another input is ignored if it is seen in the last owned cycle. The same low is granted if it is seen in the first cycle after release.
- R7: While one side owns the hub, lows on every other input have no effect on any output.
- R8: If several device ports go low in the same cycle while the hub is idle, the lowest-numbered port is granted. Its level alone is then repeated to the host.
- R9: If the host and a device port go low in the same cycle while the hub is idle, the host is granted.
- R10: The host-side enable and any device-side enable are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rx | input | 1 | Receive data from the host-side transceiver |
| host_tx | output | 1 | Transmit data to the host-side transceiver |
| host_de | output | 1 | Driver enable of the host-side transceiver |
| port_rx | input | N_PORTS | Receive data from each device-side transceiver, bit i is port i |
| port_tx | output | N_PORTS | Transmit data to each device-side transceiver |
| port_de | output | N_PORTS | Driver enable of each device-side transceiver |

## Verification
The repeater is driven with a host-originated low/high pulse, a device-originated pulse, and pulses that arrive while the opposite side already owns the hub. Together these separate broadcast routing from return-only routing and show that non-owners are ignored. Simultaneous lows, both between two device ports and between the host and a port, expose the grant priority. The owner that then goes high while the losing input stays low shows which input is actually being followed. A one-cycle low placed exactly one cycle before, and then exactly at, the end of the quiet window pins the release boundary. The enable is sampled at the first, last and first-after cycle of the hold to pin its length.

// File: rtl/hub_pkg.sv
package hub_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_PORT = 2'd2
  } owner_e;
endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '1;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hub_line_driver.sv
module hub_line_driver #(
  parameter int HOLD_CYCLES = 2200
) (
  input  logic clk,
  input  logic rst,
  input  logic want_i,
  input  logic bit_i,
  output logic tx_o,
  output logic de_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic          tx_q, de_q;
  logic [CW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= 1'b1;
      de_q   <= 1'b0;
      hold_q <= '0;
    end else if (!want_i) begin
      tx_q   <= 1'b1;
      de_q   <= 1'b0;
      hold_q <= '0;
    end else if (!bit_i) begin
      tx_q   <= 1'b0;
      de_q   <= 1'b1;
      hold_q <= CW'(HOLD_CYCLES);
    end else if (hold_q != '0) begin
      tx_q   <= 1'b1;
      de_q   <= 1'b1;
      hold_q <= hold_q - 1'b1;
    end else begin
      tx_q   <= 1'b1;
      de_q   <= 1'b0;
    end
  end

  assign tx_o = tx_q;
  assign de_o = de_q;

  // R4: a low level is always actively driven
  p_low_driven_r4: assert property (@(posedge clk) disable iff (rst) !tx_q |-> de_q);
  // R5: the enable survives the rising edge
  p_rise_held_r5: assert property (@(posedge clk) disable iff (rst) $rose(tx_q) |-> de_q);
  // R5: the enable only drops while the line is high
  p_release_high_r5: assert property (@(posedge clk) disable iff (rst) $fell(de_q) |-> tx_q);
endmodule

// File: rtl/hub_arbiter.sv
module hub_arbiter
  import hub_pkg::*;
#(
  parameter int N_PORTS        = 10,
  parameter int RELEASE_CYCLES = 208334
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_s,
  input  logic [N_PORTS-1:0] port_s,
  output logic               fwd_bit,
  output logic               to_ports,
  output logic               to_host
);
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int QW = $clog2(RELEASE_CYCLES + 1);

  owner_e        st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [QW-1:0] quiet_q, quiet_d;
  logic          low_any;
  logic [IW-1:0] low_idx;
  logic          src;

  // lowest-numbered low port wins
  always_comb begin
    low_any = 1'b0;
    low_idx = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (!port_s[i]) begin
        low_any = 1'b1;
        low_idx = IW'(i);
      end
    end
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    quiet_d = quiet_q;
    src     = 1'b1;
    case (st_q)
      OWN_IDLE: begin
        if (!host_s) begin
          st_d = OWN_HOST;
          src  = 1'b0;
        end else if (low_any) begin
          st_d  = OWN_PORT;
          idx_d = low_idx;
          src   = 1'b0;
        end
      end
      default: begin
        src = (st_q == OWN_HOST) ? host_s : port_s[idx_q];
        if (!src) begin
          quiet_d = '0;
        end else if (quiet_q == QW'(RELEASE_CYCLES - 1)) begin
          st_d    = OWN_IDLE;
          quiet_d = '0;
        end else begin
          quiet_d = quiet_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= OWN_IDLE;
      idx_q   <= '0;
      quiet_q <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      quiet_q <= quiet_d;
    end
  end

  assign fwd_bit  = src;
  assign to_ports = (st_d == OWN_HOST);
  assign to_host  = (st_d == OWN_PORT);

  // R8: the granted port does not change during ownership
  p_grant_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == OWN_PORT && $past(st_q == OWN_PORT)) |-> $stable(idx_q));
  // R6: a low on the owner always keeps ownership
  p_low_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q != OWN_IDLE && !src) |=> (st_q != OWN_IDLE));
  // R7: direction never swaps without passing through idle
  p_no_swap_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == OWN_HOST) |=> (st_q != OWN_PORT));
  p_no_swap_back_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == OWN_PORT) |=> (st_q != OWN_HOST));
endmodule

// File: rtl/star_hub_dir_ctrl.sv
module star_hub_dir_ctrl #(
  parameter int N_PORTS        = 10,
  parameter int SYNC_STAGES    = 2,
  parameter int HOLD_CYCLES    = 2200,
  parameter int RELEASE_CYCLES = 208334
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_rx,
  output logic               host_tx,
  output logic               host_de,
  input  logic [N_PORTS-1:0] port_rx,
  output logic [N_PORTS-1:0] port_tx,
  output logic [N_PORTS-1:0] port_de
);
  logic [N_PORTS:0] rx_s;
  logic             fwd_bit, to_ports, to_host;

  hub_sync #(.WIDTH(N_PORTS + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i({host_rx, port_rx}), .q_o(rx_s)
  );

  hub_arbiter #(.N_PORTS(N_PORTS), .RELEASE_CYCLES(RELEASE_CYCLES)) u_arb (
    .clk(clk), .rst(rst),
    .host_s(rx_s[N_PORTS]), .port_s(rx_s[N_PORTS-1:0]),
    .fwd_bit(fwd_bit), .to_ports(to_ports), .to_host(to_host)
  );

  hub_line_driver #(.HOLD_CYCLES(HOLD_CYCLES)) u_host_drv (
    .clk(clk), .rst(rst), .want_i(to_host), .bit_i(fwd_bit),
    .tx_o(host_tx), .de_o(host_de)
  );

  for (genvar g = 0; g < N_PORTS; g++) begin : g_port_drv
    hub_line_driver #(.HOLD_CYCLES(HOLD_CYCLES)) u_drv (
      .clk(clk), .rst(rst), .want_i(to_ports), .bit_i(fwd_bit),
      .tx_o(port_tx[g]), .de_o(port_de[g])
    );
  end

  // R10: never drive both sides at once
  p_one_direction_r10: assert property (@(posedge clk) disable iff (rst)
    !(host_de && (|port_de)));
  // R3: device ports are never driven low while the host line is driven
  p_no_echo_r3: assert property (@(posedge clk) disable iff (rst)
    host_de |-> (&port_tx));
endmodule

// File: tb/tb_star_hub_dir_ctrl.sv
module tb_star_hub_dir_ctrl;
  localparam int N    = 10;
  localparam int HOLD = 4;
  localparam int REL  = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_rx = 1'b1;
  logic         host_tx, host_de;
  logic [N-1:0] port_rx = '1;
  logic [N-1:0] port_tx, port_de;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  star_hub_dir_ctrl #(.N_PORTS(N), .SYNC_STAGES(2), .HOLD_CYCLES(HOLD),
                      .RELEASE_CYCLES(REL)) dut (
    .clk(clk), .rst(rst), .host_rx(host_rx), .host_tx(host_tx), .host_de(host_de),
    .port_rx(port_rx), .port_tx(port_tx), .port_de(port_de)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    host_rx = 1'b1;
    port_rx = '1;
    tick(REL + 12);
  endtask

  task automatic t_reset();
    chk("R1", "host_tx", 32'(host_tx), 32'd1);
    chk("R1", "host_de", 32'(host_de), 32'd0);
    chk("R1", "port_tx", 32'(port_tx), 32'h3ff);
    chk("R1", "port_de", 32'(port_de), 32'd0);
  endtask

  task automatic t_down();
    host_rx = 1'b0;
    tick(3);
    chk("R2", "port_tx broadcast low", 32'(port_tx), 32'h000);
    chk("R4", "port_de on low", 32'(port_de), 32'h3ff);
    chk("R2", "host_de off", 32'(host_de), 32'd0);
    chk("R10", "host_tx idle", 32'(host_tx), 32'd1);
    host_rx = 1'b1;
    tick(3);
    chk("R2", "port_tx broadcast high", 32'(port_tx), 32'h3ff);
    chk("R5", "port_de first hold", 32'(port_de), 32'h3ff);
    tick(HOLD - 1);
    chk("R5", "port_de last hold", 32'(port_de), 32'h3ff);
    tick(1);
    chk("R5", "port_de released", 32'(port_de), 32'h000);
    settle();
  endtask

  task automatic t_ignore();
    host_rx = 1'b0;
    tick(3);
    port_rx[3] = 1'b0;
    tick(3);
    chk("R7", "host_de with port low", 32'(host_de), 32'd0);
    chk("R7", "host_tx with port low", 32'(host_tx), 32'd1);
    chk("R7", "port_tx still host", 32'(port_tx), 32'h000);
    host_rx = 1'b1;
    tick(3);
    chk("R7", "port_tx follows host", 32'(port_tx), 32'h3ff);
    chk("R7", "host_de stays off", 32'(host_de), 32'd0);
    port_rx[3] = 1'b1;
    settle();
  endtask

  task automatic t_up();
    port_rx[5] = 1'b0;
    tick(3);
    chk("R3", "host_tx low", 32'(host_tx), 32'd0);
    chk("R4", "host_de on low", 32'(host_de), 32'd1);
    chk("R3", "port_de none", 32'(port_de), 32'd0);
    chk("R3", "port_tx none", 32'(port_tx), 32'h3ff);
    port_rx[5] = 1'b1;
    tick(3);
    chk("R5", "host_tx high", 32'(host_tx), 32'd1);
    chk("R5", "host_de held", 32'(host_de), 32'd1);
    tick(HOLD);
    chk("R5", "host_de released", 32'(host_de), 32'd0);
    settle();
  endtask

  task automatic t_tie();
    port_rx[2] = 1'b0;
    port_rx[7] = 1'b0;
    tick(3);
    chk("R8", "host_tx low", 32'(host_tx), 32'd0);
    port_rx[2] = 1'b1;
    tick(3);
    chk("R8", "host_tx follows port 2", 32'(host_tx), 32'd1);
    chk("R8", "no device driven", 32'(port_de), 32'd0);
    port_rx[7] = 1'b1;
    settle();
  endtask

  task automatic t_host_wins();
    host_rx    = 1'b0;
    port_rx[0] = 1'b0;
    tick(3);
    chk("R9", "port_tx host low", 32'(port_tx), 32'h000);
    chk("R9", "host_de off", 32'(host_de), 32'd0);
    host_rx    = 1'b1;
    port_rx[0] = 1'b1;
    settle();
  endtask

  task automatic t_release(input bit at_edge);
    host_rx = 1'b0;
    tick(3);
    host_rx = 1'b1;
    tick(at_edge ? REL : REL - 1);
    port_rx[1] = 1'b0;
    tick(1);
    port_rx[1] = 1'b1;
    tick(2);
    if (at_edge) begin
      chk("R6", "granted after release tx", 32'(host_tx), 32'd0);
      chk("R6", "granted after release de", 32'(host_de), 32'd1);
    end else begin
      chk("R6", "ignored before release tx", 32'(host_tx), 32'd1);
      chk("R6", "ignored before release de", 32'(host_de), 32'd0);
    end
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    tick(4);
    t_reset();
    rst = 1'b0;
    tick(1);
    t_reset();
    t_down();
    t_ignore();
    t_up();
    t_tie();
    t_host_wins();
    t_release(1'b0);
    t_release(1'b1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule